// File: doc/BRIEF.md
# Paged Flash Command Framer with Status Polling

This block builds the byte sequences that a page-organised serial flash expects and hands them, one byte at a time, to a byte-level SPI transfer engine. For commands that carry an address, the caller supplies a linear byte address together with the device geometry: a page size and a page offset. The page size is a runtime input and need not be a power of two. The block divides the address by the page size. It then packs the quotient, shifted left by the page offset, plus the remainder into a 24-bit device address. The frame it emits is the opcode, then the three device-address bytes, then zero filler up to the requested header length. A second frame type writes into the device's internal buffer. Its frame carries the opcode, a zero byte, and a buffer offset whose high byte is masked by a caller-supplied byte-field mask.

Two further command kinds use the device's status read, which is a two-byte exchange whose second received byte is the status. A poll command repeats the status read until bit 7 reports ready, or until a fixed number of reads has been made, which ends in a timeout result. A probe command performs one status read and decodes it into "no device present" or a density code. Only one command is in flight at a time. Any command offered while the block is busy is refused and discarded.

Top module: `pflash_cmd_framer`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `tx_valid` and `done` are low.
- R2: For kind 0 (addressed frame), the device address is `((addr / page_size) << page_offset) + (addr % page_size)`, truncated to 24 bits. It is sent as bytes 1, 2 and 3 of the frame, most significant first, and this holds for page sizes that are not powers of two.
- R3: A kind 0 frame is the opcode, then the three address bytes, then 0x00 bytes up to the header length. A header length below 4 is treated as 4, and one above 8 is treated as 8.
- R4: A kind 1 frame (buffer write) is exactly four bytes: the opcode, then 0x00, then bits [15:8] of `(cmd_addr & byte_mask)`, then bits [7:0] of `cmd_addr`.
- R5: Kinds 2 (poll) and 3 (probe) send frames of two bytes, 0xD7 then 0x00, whatever `cmd_opcode` holds. The byte received for the second position is presented on `status_byte`.
- R6: A poll repeats status frames until a received status has bit 7 set, then completes with `result` = 0.
- R7: When POLL_LIMIT (default 1000) status reads in a row all show bit 7 clear, a poll completes with `result` = 1 after exactly that many frames.
- R8: After a probe, `dev_absent` is 1 when the status is 0xFF. Otherwise `dev_absent` is 0 and `density_code` is status bits [5:2].
- R9: While `busy` is high, `cmd_valid` raises `cmd_reject` in the same cycle. The offered command is discarded and emits no bytes.
- R10: `tx_byte` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low. `tx_last` marks the final byte of each frame. The next byte is offered only after `rx_valid` has returned a response to the previous byte.
- R11: `done` is a one-cycle pulse that follows the response to the last byte of a command. The block is idle in the next cycle, and `result` and `status_byte` are valid while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offer |
| cmd_kind | input | 2 | 0 addressed, 1 buffer write, 2 poll, 3 probe |
| cmd_opcode | input | 8 | Opcode for kinds 0 and 1 |
| cmd_addr | input | ADDR_W | Linear address (kind 0) or buffer offset (kind 1) |
| cmd_hdr_len | input | HDR_W | Header length in bytes for kind 0 |
| page_size | input | PS_W | Bytes per page, nonzero |
| page_offset | input | OFF_W | Shift applied to the page number |
| byte_mask | input | 16 | Mask for the buffer-offset high byte |
| cmd_reject | output | 1 | Offer refused because busy |
| busy | output | 1 | Command in progress |
| tx_valid | output | 1 | Frame byte offered to the engine |
| tx_ready | input | 1 | Engine accepts the byte |
| tx_byte | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| rx_valid | input | 1 | Response byte for the last accepted byte |
| rx_byte | input | 8 | Response byte |
| done | output | 1 | Command complete pulse |
| result | output | 1 | 0 ok, 1 poll timeout |
| status_byte | output | 8 | Last captured status |
| dev_absent | output | 1 | Probe saw 0xFF |
| density_code | output | 4 | Status bits [5:2] |

## Verification
The hardest situation to reach is the poll timeout. It needs a full thousand consecutive not-ready responses, with no ready bit slipping in, and the framer must stop after exactly the last of them. The bench responder serves status bytes from a queue, so the stimulus loads a thousand not-ready values and the reference model counts that exactly that many status frames go out. A short poll that turns ready on its third read is issued with a rejected offer injected mid-flight. The engine's ready and response latency vary throughout, so the hold rule is exercised on every frame.

// File: rtl/pfcf_pkg.sv
// Shared types and constants for the paged flash command framer.
package pfcf_pkg;

    // Command kinds presented on cmd_kind.
    typedef enum logic [1:0] {
        KIND_ADDR  = 2'd0,
        KIND_BUFWR = 2'd1,
        KIND_POLL  = 2'd2,
        KIND_PROBE = 2'd3
    } pfcf_kind_e;

    // Completion results.
    typedef enum logic {
        RES_OK      = 1'b0,
        RES_TIMEOUT = 1'b1
    } pfcf_res_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV,
        S_SEND,
        S_WAIT,
        S_FIN
    } pfcf_state_e;

    localparam logic [7:0] STATUS_OPCODE = 8'hD7;
    localparam int         DEV_W         = 24;

endpackage

// File: rtl/pfcf_page_split.sv
// Iterative page/byte address converter.
// Divides a linear address by a runtime page size with one restoring
// division step per clock (ADDR_W cycles). It then forms
// (quotient << offset) + remainder, truncated to DEV_W bits.
// Assumes page_size is nonzero and that start only arrives when idle.
module pfcf_page_split #(
    parameter int ADDR_W = 22,
    parameter int PS_W   = 11,
    parameter int OFF_W  = 4,
    parameter int DEV_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] lin_addr,
    input  logic [PS_W-1:0]   page_size,
    input  logic [OFF_W-1:0]  page_off,
    output logic              done,
    output logic [DEV_W-1:0]  dev_addr
);
    localparam int CNT_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] dvd_q;
    logic [PS_W-1:0]   rem_q;
    logic [PS_W-1:0]   div_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic [PS_W:0]     trial;
    logic              fits;

    // Partial remainder with the next dividend bit brought down.
    always_comb begin
        trial = {rem_q, dvd_q[ADDR_W-1]};
        fits  = (trial >= {1'b0, div_q});
    end

    // One restoring-division step per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            rem_q <= '0;
            div_q <= '0;
            off_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvd_q <= lin_addr;
                rem_q <= '0;
                div_q <= page_size;
                off_q <= page_off;
                cnt_q <= CNT_W'(ADDR_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? PS_W'(trial - {1'b0, div_q}) : PS_W'(trial);
                dvd_q <= {dvd_q[ADDR_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    // Repack page number and byte index into the device format.
    always_comb begin
        dev_addr = (DEV_W'(dvd_q) << off_q) + DEV_W'(rem_q);
    end

endmodule

// File: rtl/pfcf_frame_byte.sv
// Frame byte selector.
// Gives the byte at position idx of the current frame, and whether it is
// the frame's last byte, for each command kind. Purely combinational.
// Assumes MIN_HDR >= 4 so that the address bytes always fit.
module pfcf_frame_byte
    import pfcf_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int HDR_W   = 4,
    parameter int MIN_HDR = 4,
    parameter int MAX_HDR = 8
) (
    input  pfcf_kind_e        kind,
    input  logic [7:0]        opcode,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [15:0]       buf_off,
    input  logic [15:0]       byte_mask,
    input  logic [HDR_W-1:0]  hdr_len,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        fbyte,
    output logic              flast
);
    int          len;
    logic [15:0] masked_off;

    // Frame length per kind, with the header length clamped.
    always_comb begin
        case (kind)
            KIND_ADDR: begin
                if (int'(hdr_len) < MIN_HDR)      len = MIN_HDR;
                else if (int'(hdr_len) > MAX_HDR) len = MAX_HDR;
                else                              len = int'(hdr_len);
            end
            KIND_BUFWR: len = 4;
            default:    len = 2;
        endcase
        flast = (int'(idx) == len - 1);
    end

    // Byte content per position and kind.
    always_comb begin
        masked_off = buf_off & byte_mask;
        fbyte      = 8'h00;
        case (int'(idx))
            0: fbyte = (kind == KIND_POLL || kind == KIND_PROBE) ? STATUS_OPCODE : opcode;
            1: fbyte = (kind == KIND_ADDR) ? dev_addr[23:16] : 8'h00;
            2: begin
                if (kind == KIND_ADDR)       fbyte = dev_addr[15:8];
                else if (kind == KIND_BUFWR) fbyte = masked_off[15:8];
            end
            3: begin
                if (kind == KIND_ADDR)       fbyte = dev_addr[7:0];
                else if (kind == KIND_BUFWR) fbyte = buf_off[7:0];
            end
            default: fbyte = 8'h00;
        endcase
    end

endmodule

// File: rtl/pfcf_status_eval.sv
// Status byte decoder for device detection.
// An all-ones status means that nothing drives the data line.
// Otherwise the density field sits in bits [5:2].
module pfcf_status_eval (
    input  logic [7:0] status,
    output logic       absent,
    output logic [3:0] density
);
    // Detection decode.
    always_comb begin
        absent  = (status == 8'hFF);
        density = absent ? 4'h0 : status[5:2];
    end
endmodule

// File: rtl/pflash_cmd_framer.sv
// Paged flash command framer, top level.
// Accepts one command at a time and sequences it as follows:
//   address split (kind 0 only) -> byte send -> response wait -> ... -> done.
// The poll kind loops status frames up to POLL_LIMIT times.
// Assumes the engine returns exactly one rx_valid per accepted byte.
module pflash_cmd_framer
    import pfcf_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int PS_W       = 11,
    parameter int OFF_W      = 4,
    parameter int HDR_W      = 4,
    parameter int MIN_HDR    = 4,
    parameter int MAX_HDR    = 8,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [7:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [HDR_W-1:0]  cmd_hdr_len,
    input  logic [PS_W-1:0]   page_size,
    input  logic [OFF_W-1:0]  page_offset,
    input  logic [15:0]       byte_mask,
    output logic              cmd_reject,
    output logic              busy,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              done,
    output logic              result,
    output logic [7:0]        status_byte,
    output logic              dev_absent,
    output logic [3:0]        density_code
);
    localparam int IDX_W  = $clog2(MAX_HDR);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    pfcf_state_e       state;
    pfcf_kind_e        kind_in;
    pfcf_kind_e        kind_q;
    logic [7:0]        op_q;
    logic [15:0]       off_q;
    logic [15:0]       mask_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [IDX_W-1:0]  idx;
    logic [POLL_W-1:0] poll_cnt;
    logic [7:0]        status_q;
    pfcf_res_e         result_q;
    logic              div_start;
    logic              div_done;
    logic [DEV_W-1:0]  dev_addr;
    logic [7:0]        fbyte;
    logic              flast;
    logic              is_status;

    // Command decode and handshake outputs.
    always_comb begin
        kind_in    = pfcf_kind_e'(cmd_kind);
        busy       = (state != S_IDLE);
        cmd_reject = cmd_valid && busy;
        div_start  = (state == S_IDLE) && cmd_valid && (kind_in == KIND_ADDR);
        tx_valid   = (state == S_SEND);
        tx_byte    = fbyte;
        tx_last    = flast;
        done       = (state == S_FIN);
        result     = result_q;
        status_byte = status_q;
        is_status  = (kind_q == KIND_POLL) || (kind_q == KIND_PROBE);
    end

    pfcf_page_split #(
        .ADDR_W (ADDR_W),
        .PS_W   (PS_W),
        .OFF_W  (OFF_W),
        .DEV_W  (DEV_W)
    ) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .lin_addr  (cmd_addr),
        .page_size (page_size),
        .page_off  (page_offset),
        .done      (div_done),
        .dev_addr  (dev_addr)
    );

    pfcf_frame_byte #(
        .IDX_W   (IDX_W),
        .HDR_W   (HDR_W),
        .MIN_HDR (MIN_HDR),
        .MAX_HDR (MAX_HDR)
    ) u_frame (
        .kind      (kind_q),
        .opcode    (op_q),
        .dev_addr  (dev_addr),
        .buf_off   (off_q),
        .byte_mask (mask_q),
        .hdr_len   (hdr_q),
        .idx       (idx),
        .fbyte     (fbyte),
        .flast     (flast)
    );

    pfcf_status_eval u_status (
        .status  (status_q),
        .absent  (dev_absent),
        .density (density_code)
    );

    // Command sequencer: accept, split, send, await response, loop or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            kind_q   <= KIND_ADDR;
            op_q     <= '0;
            off_q    <= '0;
            mask_q   <= '0;
            hdr_q    <= '0;
            idx      <= '0;
            poll_cnt <= '0;
            status_q <= '0;
            result_q <= RES_OK;
        end else begin
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        kind_q   <= kind_in;
                        op_q     <= cmd_opcode;
                        off_q    <= 16'(cmd_addr);
                        mask_q   <= byte_mask;
                        hdr_q    <= cmd_hdr_len;
                        idx      <= '0;
                        poll_cnt <= '0;
                        state    <= (kind_in == KIND_ADDR) ? S_DIV : S_SEND;
                    end
                end
                S_DIV: begin
                    if (div_done) state <= S_SEND;
                end
                S_SEND: begin
                    if (tx_ready) state <= S_WAIT;
                end
                S_WAIT: begin
                    if (rx_valid) begin
                        if (is_status && idx == IDX_W'(1)) status_q <= rx_byte;
                        if (!flast) begin
                            idx   <= idx + 1'b1;
                            state <= S_SEND;
                        end else if (kind_q == KIND_POLL && !rx_byte[7]) begin
                            if (poll_cnt == POLL_W'(POLL_LIMIT - 1)) begin
                                result_q <= RES_TIMEOUT;
                                state    <= S_FIN;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                                idx      <= '0;
                                state    <= S_SEND;
                            end
                        end else begin
                            result_q <= RES_OK;
                            state    <= S_FIN;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pfcf_checker.sv
// Protocol checker for the command framer, bound to the top module.
module pfcf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte,
    input logic       tx_last,
    input logic       done,
    input logic       result,
    input logic [7:0] status_byte
);
    // R10: an offered byte is held until the engine takes it.
    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

    // R9: an offer made while idle is taken, so the block is busy next cycle.
    assert_accept_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> busy);

    // R11: the block is idle in the cycle after completion.
    assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11: no byte is offered while completion is signalled.
    assert_done_no_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_valid);

    // R7: a timeout is only reported with a not-ready status.
    assert_timeout_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && result |-> !status_byte[7]);
endmodule

bind pflash_cmd_framer pfcf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_byte     (tx_byte),
    .tx_last     (tx_last),
    .done        (done),
    .result      (result),
    .status_byte (status_byte)
);

// File: tb/pflash_cmd_framer_tb.sv
module pflash_cmd_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 22;
    localparam int PS_W       = 11;
    localparam int OFF_W      = 4;
    localparam int HDR_W      = 4;
    localparam int LIMIT      = 1000;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_kind = '0;
    logic [7:0]        cmd_opcode = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [HDR_W-1:0]  cmd_hdr_len = '0;
    logic [PS_W-1:0]   page_size = 11'd264;
    logic [OFF_W-1:0]  page_offset = 4'd9;
    logic [15:0]       byte_mask = 16'h01FF;
    logic              cmd_reject, busy, tx_valid, tx_last, done, result, dev_absent;
    logic              tx_ready = 1'b0;
    logic [7:0]        tx_byte, status_byte;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic [3:0]        density_code;

    pflash_cmd_framer u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_hdr_len(cmd_hdr_len),
        .page_size(page_size), .page_offset(page_offset), .byte_mask(byte_mask),
        .cmd_reject(cmd_reject), .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .tx_last(tx_last), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .done(done), .result(result), .status_byte(status_byte),
        .dev_absent(dev_absent), .density_code(density_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] exp_b[$];
    bit         exp_l[$];
    logic [7:0] stat_q[$];
    int         cur_kind = 0;
    bit         pending = 0;
    int         exp_res, exp_stat, exp_abs, exp_dens;
    int         pos = 0;
    bit         pend_rx = 0;
    int         dly = 0;
    logic [7:0] pend_byte;
    int         rdy_seq = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Byte-level engine model and cycle-by-cycle comparison against the reference queues.
    always @(negedge clk) begin
        if (rst_n) begin
            rdy_seq++;
            tx_ready = ((rdy_seq % 4) != 3);
            if (rx_valid) rx_valid = 1'b0;
            if (pend_rx) begin
                if (dly == 0) begin
                    rx_valid = 1'b1;
                    rx_byte  = pend_byte;
                    pend_rx  = 0;
                end else dly--;
            end
            if (tx_valid && tx_ready) begin
                logic [7:0] resp;
                if (exp_b.size() == 0) begin
                    chk("R10 unexpected byte", 1, 0);
                end else begin
                    chk("frame byte R2 R3 R4 R5", tx_byte, exp_b.pop_front());
                    chk("R10 tx_last", tx_last, exp_l.pop_front());
                end
                resp = 8'h5A;
                if (cur_kind >= 2 && pos == 1) resp = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h00;
                pos = tx_last ? 0 : pos + 1;
                pend_rx = 1;
                dly = rdy_seq % 3;
                pend_byte = resp;
            end
            if (done) begin
                if (!pending) chk("R11 spurious done", 1, 0);
                else begin
                    chk("R11 frame complete at done", exp_b.size(), 0);
                    chk("R6 R7 result", result, exp_res);
                    if (cur_kind >= 2) chk("R5 status byte", status_byte, exp_stat);
                    if (cur_kind == 3) begin
                        chk("R8 absent", dev_absent, exp_abs);
                        if (!exp_abs) chk("R8 density", density_code, exp_dens);
                    end
                end
                pending = 0;
            end
        end
    end

    task automatic push(input int b, input bit l);
        exp_b.push_back(8'(b));
        exp_l.push_back(l);
    endtask

    task automatic issue(input int kind, input int op, input longint addr, input int hdr,
                         input int ps, input int off, input int mask, input bit do_reject);
        longint da;
        int len;
        int n;
        bit rdy;
        case (kind)
            0: begin
                da = (((addr / ps) << off) + (addr % ps)) & 64'hFFFFFF;
                len = (hdr < 4) ? 4 : (hdr > 8) ? 8 : hdr;
                push(op, 0); push(int'(da >> 16) & 255, 0);
                push(int'(da >> 8) & 255, 0); push(int'(da) & 255, len == 4);
                for (int i = 4; i < len; i++) push(0, i == len - 1);
                exp_res = 0;
            end
            1: begin
                push(op, 0); push(0, 0);
                push((int'(addr & mask) >> 8) & 255, 0); push(int'(addr) & 255, 1);
                exp_res = 0;
            end
            2: begin
                n = LIMIT; rdy = 0;
                for (int i = 0; i < LIMIT && i < stat_q.size(); i++)
                    if (stat_q[i][7]) begin n = i + 1; rdy = 1; break; end
                for (int i = 0; i < n; i++) begin push(8'hD7, 0); push(0, 1); end
                exp_res = rdy ? 0 : 1;
                exp_stat = stat_q[n-1];
            end
            default: begin
                push(8'hD7, 0); push(0, 1);
                exp_res = 0;
                exp_stat = stat_q[0];
                exp_abs = (stat_q[0] == 8'hFF);
                exp_dens = (stat_q[0] >> 2) & 15;
            end
        endcase
        cur_kind = kind; pending = 1; pos = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_kind = 2'(kind); cmd_opcode = 8'(op);
        cmd_addr = ADDR_W'(addr); cmd_hdr_len = HDR_W'(hdr);
        page_size = PS_W'(ps); page_offset = OFF_W'(off); byte_mask = 16'(mask);
        @(negedge clk);
        cmd_valid = 0;
        if (do_reject) begin
            repeat (2) @(negedge clk);
            cmd_valid = 1; cmd_kind = 2'd0; cmd_opcode = 8'hEE;
            #1 chk("R9 cmd_reject while busy", cmd_reject, 1);
            @(negedge clk);
            cmd_valid = 0;
        end
        while (pending) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(negedge clk);
        chk("watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 tx_valid after reset", tx_valid, 0);
        chk("R1 done after reset", done, 0);
        rst_n = 1;
        // R2 R3: continuous-read style header, non-power-of-two page
        issue(0, 8'hE8, 1000, 8, 264, 9, 16'h01FF, 0);
        // R2 R3: 4-byte header, larger page
        issue(0, 8'h53, 2640, 4, 528, 10, 16'h03FF, 0);
        // R2: power-of-two page is an identity mapping
        issue(0, 8'h82, 64'h12345, 4, 256, 8, 16'h00FF, 0);
        // R2: top of the address range
        issue(0, 8'h55, (1 << ADDR_W) - 1, 4, 1056, 11, 16'h07FF, 0);
        // R3: header length clamping at both ends
        issue(0, 8'h58, 77, 2, 264, 9, 16'h01FF, 0);
        issue(0, 8'hE8, 77, 15, 264, 9, 16'h01FF, 0);
        // R2: assorted addresses and geometries
        for (int k = 0; k < 8; k++) begin
            int ps_tab[5] = '{264, 528, 1056, 256, 512};
            int of_tab[5] = '{9, 10, 11, 8, 9};
            issue(0, 8'h83, longint'($urandom % (1 << ADDR_W)), 4 + k % 5,
                  ps_tab[k % 5], of_tab[k % 5], 16'h01FF, 0);
        end
        // R4: buffer writes with the mask trimming the high byte
        issue(1, 8'h84, 16'h03A5, 0, 264, 9, 16'h01FF, 0);
        issue(1, 8'h87, 16'h0412, 0, 1056, 11, 16'h07FF, 0);
        // R6 R9: ready on the third read, with a refused offer mid-flight
        stat_q.push_back(8'h1C); stat_q.push_back(8'h3C); stat_q.push_back(8'hBC);
        issue(2, 0, 0, 0, 264, 9, 16'h01FF, 1);
        // R6: ready at once
        stat_q.push_back(8'hA4);
        issue(2, 0, 0, 0, 264, 9, 16'h01FF, 0);
        // R7: never ready
        for (int i = 0; i < LIMIT; i++) stat_q.push_back(8'h3C);
        issue(2, 0, 0, 0, 264, 9, 16'h01FF, 0);
        // R8: probe with no device, then with a density code
        stat_q.push_back(8'hFF);
        issue(3, 0, 0, 0, 264, 9, 16'h01FF, 0);
        stat_q.push_back(8'h9C);
        issue(3, 0, 0, 0, 264, 9, 16'h01FF, 0);
        chk("R9 no stray bytes", exp_b.size(), 0);
        summary();
        $finish;
    end
endmodule